// File: doc/BRIEF.md
# Serially loaded cartridge bank mapper

This block sits between a console CPU and PPU and the memories of a game cartridge. It turns CPU addresses in 0x8000–0xFFFF into wide program-ROM addresses and PPU pattern addresses in 0x0000–0x1FFF into wide character-memory addresses. It also produces a work-RAM enable for the 0x6000–0x7FFF window and a nametable page select that carries out the mirroring. The address translation is combinational. Only the configuration state is held in flops.

Software sets up the mapper through a serial loader. Each CPU write outside the work-RAM window carries one configuration bit in data bit 0. A write with data bit 7 set resets the loader. The fifth bit completes a 5-bit value. That value goes to one of four registers, picked by the address of the fifth write: the control register, character bank 0, character bank 1, or the program bank.

Top module: `serial_bank_mapper`

## Requirements
- R1: After reset the mapper is in PRG mode 3, CHR mode 0 and one-screen upper-page mirroring (page select 1), all bank registers are 0 and work RAM is enabled.
- R2: A write to 0x6000–0x7FFF has no effect on the serial loader, whatever its data, including data bit 7.
- R3: A write outside 0x6000–0x7FFF with data bit 7 set empties the loader and forces the PRG mode to 3, leaving the other control fields unchanged.
- R4: Without bit 7 set, each loader write shifts in data bit 0, first write into value bit 0. The first four writes change no register. The fifth commits the value and empties the loader.
- R5: The control register is written from 0x8000–0x9FFF. Value bits [1:0] are the mirroring, bits [3:2] the PRG mode and bit 4 the CHR mode.
- R6: Mirroring 0 drives page select 1, mirroring 1 drives 0, mirroring 2 (vertical) drives PPU A10 and mirroring 3 (horizontal) drives PPU A11.
- R7: PRG banks are 16 KiB: prg_addr = {bank, cpu_addr[13:0]}. Modes 0/1 map one 32 KiB window as {prg[3:1], cpu_addr[14]}. Mode 2 puts bank 0 at 0x8000 and the register at 0xC000. Mode 3 puts the register at 0x8000 and bank 15 at 0xC000.
- R8: CHR banks are 4 KiB: chr_addr = {bank, ppu_addr[11:0]}. CHR mode 0 uses {chr0[4:1], ppu_addr[12]}. Mode 1 uses chr0 below 0x1000 and chr1 from 0x1000.
- R9: Fifth writes to 0xA000–0xBFFF load CHR register 0 and to 0xC000–0xDFFF load CHR register 1. A fifth write below 0x8000 loads no register.
- R10: A value committed from 0xE000–0xFFFF sets the PRG bank from bits [3:0]. Bit 4 = 1 drops the work-RAM enable for 0x6000–0x7FFF, and bit 4 = 0 restores it.
- R11: A committed value steers translation from the clock edge that ends the fifth write. During that write cycle the old configuration still applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data (bits 7 and 0 are used) |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| ppu_addr | input | 13 | PPU address bits [12:0] |
| prg_addr | output | 18 | Program ROM address |
| wram_en | output | 1 | Work-RAM enable for the 0x6000–0x7FFF window |
| chr_addr | output | 17 | Character memory address |
| nt_page_sel | output | 1 | Nametable page select (mirroring) |

## Verification
The commit of a loaded value and the translation of the CPU address carrying that fifth write happen in the same cycle. The bench holds the fifth write to 0x8000 and reads prg_addr before the edge, where the old fixed-first mode must show, and after it, where the new mode must show. It also places a clear write in the middle of a partly loaded value and work-RAM writes in the middle of a load. It then judges whether the register that the next value reaches holds the expected value.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
  typedef enum logic [1:0] {
    MIR_ONE_HI = 2'd0,
    MIR_ONE_LO = 2'd1,
    MIR_VERT   = 2'd2,
    MIR_HORZ   = 2'd3
  } mirror_e;

  typedef enum logic [1:0] {
    PRG_WIDE_A    = 2'd0,
    PRG_WIDE_B    = 2'd1,
    PRG_FIX_FIRST = 2'd2,
    PRG_FIX_LAST  = 2'd3
  } prg_mode_e;

  // bit 4: chr split, bits 3:2 prg mode, bits 1:0 mirroring
  typedef struct packed {
    logic      chr_split;
    prg_mode_e prg_mode;
    mirror_e   mirror;
  } ctrl_t;
endpackage

// File: rtl/sbm_serial_loader.sv
module sbm_serial_loader #(
  parameter int LOAD_LEN = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_stb,
  input  logic                wram_hit,
  input  logic                bit_in,
  input  logic                clr_in,
  output logic                clr_evt,
  output logic                done,
  output logic [LOAD_LEN-1:0] done_val
);
  localparam int CW = $clog2(LOAD_LEN);
  localparam logic [CW-1:0] LAST = CW'(LOAD_LEN - 1);

  logic [LOAD_LEN-1:0] shift_q, shift_d;
  logic [CW-1:0]       cnt_q, cnt_d;
  logic                act;

  assign act      = wr_stb & ~wram_hit;
  assign done_val = {bit_in, shift_q[LOAD_LEN-1:1]};

  always_comb begin
    shift_d = shift_q;
    cnt_d   = cnt_q;
    clr_evt = 1'b0;
    done    = 1'b0;
    if (act) begin
      if (clr_in) begin
        clr_evt = 1'b1;
        shift_d = '0;
        cnt_d   = '0;
      end else if (cnt_q == LAST) begin
        done    = 1'b1;
        shift_d = '0;
        cnt_d   = '0;
      end else begin
        shift_d = done_val;
        cnt_d   = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      cnt_q   <= '0;
    end else if (act) begin
      shift_q <= shift_d;
      cnt_q   <= cnt_d;
    end
  end

  // R2: work-RAM writes leave the loader untouched
  p_wram_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wram_hit) |=> ($stable(cnt_q) && $stable(shift_q)));

  // R3: a clear write empties the loader
  p_clear_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !wram_hit && clr_in) |=> (cnt_q == '0 && shift_q == '0));

  // R4: a commit leaves the loader empty for the next value
  p_commit_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (cnt_q == '0));
endmodule

// File: rtl/sbm_prg_window.sv
module sbm_prg_window
  import sbm_pkg::*;
#(
  parameter int PRG_BANKS = 16
) (
  input  prg_mode_e                      mode,
  input  logic [$clog2(PRG_BANKS)-1:0]   bank_reg,
  input  logic                           upper_half,
  output logic [$clog2(PRG_BANKS)-1:0]   bank_sel
);
  localparam int BW = $clog2(PRG_BANKS);
  localparam logic [BW-1:0] LAST_BANK = BW'(PRG_BANKS - 1);

  always_comb begin
    unique case (mode)
      PRG_FIX_FIRST: bank_sel = upper_half ? bank_reg : '0;
      PRG_FIX_LAST:  bank_sel = upper_half ? LAST_BANK : bank_reg;
      default:       bank_sel = {bank_reg[BW-1:1], upper_half};
    endcase
  end
endmodule

// File: rtl/sbm_chr_window.sv
module sbm_chr_window #(
  parameter int CHR_BANKS = 32
) (
  input  logic                           split,
  input  logic [$clog2(CHR_BANKS)-1:0]   lo_reg,
  input  logic [$clog2(CHR_BANKS)-1:0]   hi_reg,
  input  logic                           upper_half,
  output logic [$clog2(CHR_BANKS)-1:0]   bank_sel
);
  localparam int BW = $clog2(CHR_BANKS);

  always_comb begin
    if (split) bank_sel = upper_half ? hi_reg : lo_reg;
    else       bank_sel = {lo_reg[BW-1:1], upper_half};
  end
endmodule

// File: rtl/sbm_mirror.sv
module sbm_mirror
  import sbm_pkg::*;
(
  input  mirror_e mode,
  input  logic    ppu_a10,
  input  logic    ppu_a11,
  output logic    page_sel
);
  always_comb begin
    unique case (mode)
      MIR_ONE_HI: page_sel = 1'b1;
      MIR_ONE_LO: page_sel = 1'b0;
      MIR_VERT:   page_sel = ppu_a10;
      default:    page_sel = ppu_a11;
    endcase
  end
endmodule

// File: rtl/serial_bank_mapper.sv
module serial_bank_mapper
  import sbm_pkg::*;
#(
  parameter int PRG_BANKS = 16,
  parameter int CHR_BANKS = 32,
  parameter int LOAD_LEN  = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cpu_addr,
  input  logic [7:0]  cpu_data,
  input  logic        cpu_wr,
  input  logic [12:0] ppu_addr,
  output logic [17:0] prg_addr,
  output logic        wram_en,
  output logic [16:0] chr_addr,
  output logic        nt_page_sel
);
  localparam int PBW = $clog2(PRG_BANKS);
  localparam int CBW = $clog2(CHR_BANKS);
  localparam ctrl_t CTRL_RST = '{chr_split: 1'b0, prg_mode: PRG_FIX_LAST, mirror: MIR_ONE_HI};

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  logic data_unused;
  assign data_unused = ^cpu_data[6:1];

  logic                wram_hit;
  logic                ld_clr, ld_done;
  logic [LOAD_LEN-1:0] ld_val;
  assign wram_hit = (cpu_addr[15:13] == 3'b011);

  sbm_serial_loader #(.LOAD_LEN(LOAD_LEN)) u_loader (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .wr_stb   (cpu_wr),
    .wram_hit (wram_hit),
    .bit_in   (cpu_data[0]),
    .clr_in   (cpu_data[7]),
    .clr_evt  (ld_clr),
    .done     (ld_done),
    .done_val (ld_val)
  );

  // configuration registers
  ctrl_t               ctrl_q, ctrl_d;
  logic [LOAD_LEN-1:0] chr0_q, chr0_d, chr1_q, chr1_d, prg_q, prg_d;
  logic                cfg_en;

  assign cfg_en = ld_clr | ld_done;

  always_comb begin
    ctrl_d = ctrl_q;
    chr0_d = chr0_q;
    chr1_d = chr1_q;
    prg_d  = prg_q;
    if (ld_clr) begin
      ctrl_d.prg_mode = PRG_FIX_LAST;
    end else if (ld_done && cpu_addr[15]) begin
      unique case (cpu_addr[14:13])
        2'b00:   ctrl_d = ctrl_t'(ld_val);
        2'b01:   chr0_d = ld_val;
        2'b10:   chr1_d = ld_val;
        default: prg_d  = ld_val;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      ctrl_q <= CTRL_RST;
      chr0_q <= '0;
      chr1_q <= '0;
      prg_q  <= '0;
    end else if (cfg_en) begin
      ctrl_q <= ctrl_d;
      chr0_q <= chr0_d;
      chr1_q <= chr1_d;
      prg_q  <= prg_d;
    end
  end

  // translation
  logic [PBW-1:0] prg_bank;
  logic [CBW-1:0] chr_bank;

  sbm_prg_window #(.PRG_BANKS(PRG_BANKS)) u_prg (
    .mode       (ctrl_q.prg_mode),
    .bank_reg   (prg_q[PBW-1:0]),
    .upper_half (cpu_addr[14]),
    .bank_sel   (prg_bank)
  );

  sbm_chr_window #(.CHR_BANKS(CHR_BANKS)) u_chr (
    .split      (ctrl_q.chr_split),
    .lo_reg     (chr0_q[CBW-1:0]),
    .hi_reg     (chr1_q[CBW-1:0]),
    .upper_half (ppu_addr[12]),
    .bank_sel   (chr_bank)
  );

  sbm_mirror u_mir (
    .mode     (ctrl_q.mirror),
    .ppu_a10  (ppu_addr[10]),
    .ppu_a11  (ppu_addr[11]),
    .page_sel (nt_page_sel)
  );

  assign prg_addr = {prg_bank, cpu_addr[13:0]};
  assign chr_addr = {chr_bank, ppu_addr[11:0]};
  assign wram_en  = wram_hit & ~prg_q[LOAD_LEN-1];

  // R3: clear forces last-bank-fixed mode, other control fields kept
  p_clear_mode_r3: assert property (@(posedge clk) disable iff (!rst_s_n)
    ld_clr |=> (ctrl_q.prg_mode == PRG_FIX_LAST && ctrl_q.mirror == $past(ctrl_q.mirror)
                && ctrl_q.chr_split == $past(ctrl_q.chr_split)));

  // R10: fifth write at 0xE000-0xFFFF lands in the program bank register
  p_commit_prg_r10: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ld_done && cpu_addr[15:13] == 3'b111) |=> (prg_q == $past(ld_val)));

  // R9: a completed value below 0x8000 changes no register
  p_gap_ignore_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ld_done && !cpu_addr[15]) |=> ($stable(ctrl_q) && $stable(chr0_q)
                                    && $stable(chr1_q) && $stable(prg_q)));

  // R7: in mode 3 the upper window always maps the last bank
  p_fixed_last_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ctrl_q.prg_mode == PRG_FIX_LAST && cpu_addr[15:14] == 2'b11)
      |-> (prg_addr[17:14] == 4'(PRG_BANKS - 1)));
endmodule

// File: tb/test_serial_bank_mapper.sv
module test_serial_bank_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_data = '0;
  logic        cpu_wr = 1'b0;
  logic [12:0] ppu_addr = '0;
  logic [17:0] prg_addr;
  logic        wram_en;
  logic [16:0] chr_addr;
  logic        nt_page_sel;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  serial_bank_mapper i_serial_bank_mapper (
    .clk, .rst_n, .cpu_addr, .cpu_data, .cpu_wr, .ppu_addr,
    .prg_addr, .wram_en, .chr_addr, .nt_page_sel
  );

  localparam int NV = 10;
  localparam logic [4:0]  V_CTRL [NV] = '{5'h0C, 5'h0C, 5'h08, 5'h09, 5'h00, 5'h04, 5'h1E, 5'h1E, 5'h1F, 5'h1F};
  localparam logic [4:0]  V_PRG  [NV] = '{5'h05, 5'h05, 5'h09, 5'h09, 5'h09, 5'h09, 5'h00, 5'h00, 5'h00, 5'h00};
  localparam logic [4:0]  V_CHR0 [NV] = '{5'h06, 5'h07, 5'h03, 5'h03, 5'h00, 5'h00, 5'h11, 5'h11, 5'h11, 5'h11};
  localparam logic [4:0]  V_CHR1 [NV] = '{5'h00, 5'h00, 5'h00, 5'h00, 5'h00, 5'h00, 5'h1F, 5'h1F, 5'h1F, 5'h1F};
  localparam logic [15:0] V_CA   [NV] = '{16'h8123, 16'hC001, 16'h8010, 16'hC010, 16'h8004, 16'hFFFF, 16'h8000, 16'h8000, 16'hC000, 16'h8000};
  localparam logic [12:0] V_PA   [NV] = '{13'h0456, 13'h1456, 13'h0000, 13'h0800, 13'h1FFF, 13'h0000, 13'h1400, 13'h0800, 13'h0800, 13'h0400};
  localparam logic [17:0] V_EPRG [NV] = '{18'h14123, 18'h3C001, 18'h00010, 18'h24010, 18'h20004, 18'h27FFF, 18'h00000, 18'h00000, 18'h3C000, 18'h00000};
  localparam logic [16:0] V_ECHR [NV] = '{17'h06456, 17'h07456, 17'h02000, 17'h02800, 17'h01FFF, 17'h00000, 17'h1F400, 17'h11800, 17'h11800, 17'h11400};
  localparam logic        V_ENT  [NV] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_data = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic load5(input logic [15:0] a, input logic [4:0] v);
    for (int k = 0; k < 5; k++) cpu_write(a, {7'd0, v[k]});
  endtask

  task automatic probe(input logic [15:0] ca, input logic [12:0] pa);
    @(negedge clk);
    cpu_addr = ca; ppu_addr = pa;
    #1;
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    probe(16'hC000, 13'h1000);
    check("R1 prg last bank", 32'(prg_addr), 32'h3C000);
    check("R1 chr mode 0", 32'(chr_addr), 32'h01000);
    check("R1 page sel upper", 32'(nt_page_sel), 32'h1);
    probe(16'h6000, 13'h0000);
    check("R1 wram enabled", 32'(wram_en), 32'h1);
    probe(16'h8000, 13'h0000);
    check("R1 prg bank 0", 32'(prg_addr), 32'h00000);

    // R5 R6 R7 R8 vector table
    for (int i = 0; i < NV; i++) begin
      load5(16'h8000, V_CTRL[i]);
      load5(16'hE000, V_PRG[i]);
      load5(16'hA000, V_CHR0[i]);
      load5(16'hC000, V_CHR1[i]);
      probe(V_CA[i], V_PA[i]);
      check($sformatf("R7 R5 vec %0d prg", i), 32'(prg_addr), 32'(V_EPRG[i]));
      check($sformatf("R8 R9 vec %0d chr", i), 32'(chr_addr), 32'(V_ECHR[i]));
      check($sformatf("R6 vec %0d page", i), 32'(nt_page_sel), 32'(V_ENT[i]));
    end

    // R2 work-RAM writes interleaved in a control load (0x19)
    load5(16'hE000, 5'h06);
    cpu_write(16'h8000, 8'h01);
    cpu_write(16'h8000, 8'h00);
    cpu_write(16'h6000, 8'h80);
    cpu_write(16'h6000, 8'h01);
    cpu_write(16'h8000, 8'h00);
    cpu_write(16'h8000, 8'h01);
    cpu_write(16'h8000, 8'h01);
    probe(16'h8000, 13'h0400);
    check("R2 mode 2 after interleave", 32'(prg_addr), 32'h00000);
    check("R2 mirror 1", 32'(nt_page_sel), 32'h0);

    // R3 clear in the middle of a load
    cpu_write(16'h8000, 8'h01);
    cpu_write(16'h8000, 8'h01);
    cpu_write(16'h8000, 8'h80);
    probe(16'h8000, 13'h0400);
    check("R3 mode forced to 3", 32'(prg_addr), 32'h18000);
    check("R3 mirror kept", 32'(nt_page_sel), 32'h0);
    load5(16'h8000, 5'h1B);
    probe(16'hC000, 13'h0800);
    check("R3 R4 fresh load after clear", 32'(prg_addr), 32'h18000);
    check("R3 R6 horizontal", 32'(nt_page_sel), 32'h1);

    // R4 four writes commit nothing, fifth does
    cpu_write(16'hA000, 8'h00);
    cpu_write(16'hA000, 8'h01);
    cpu_write(16'hA000, 8'h00);
    cpu_write(16'hA000, 8'h00);
    probe(16'h8000, 13'h0400);
    check("R4 no commit after four", 32'(chr_addr), 32'h11400);
    cpu_write(16'hA000, 8'h00);
    probe(16'h8000, 13'h0400);
    check("R4 commit on fifth", 32'(chr_addr), 32'h02400);

    // R9 completed value below 0x8000 ignored
    load5(16'h5000, 5'h00);
    probe(16'h8000, 13'h0800);
    check("R9 ctrl unchanged prg", 32'(prg_addr), 32'h00000);
    check("R9 chr unchanged", 32'(chr_addr), 32'h02800);

    // R10 bank bits and work-RAM disable
    load5(16'hE000, 5'h13);
    probe(16'h6000, 13'h0000);
    check("R10 wram disabled", 32'(wram_en), 32'h0);
    probe(16'hC000, 13'h0000);
    check("R10 bank 3", 32'(prg_addr), 32'h0C000);
    load5(16'hE000, 5'h03);
    probe(16'h6000, 13'h0000);
    check("R10 wram enabled", 32'(wram_en), 32'h1);

    // R11 commit timing: ctrl 0x0F, old mode 2 visible during fifth write
    for (int k = 0; k < 4; k++) cpu_write(16'h8000, 8'h01);
    @(negedge clk);
    cpu_addr = 16'h8000; cpu_data = 8'h00; cpu_wr = 1'b1;
    #1;
    check("R11 old mode during write", 32'(prg_addr), 32'h00000);
    @(negedge clk);
    cpu_wr = 1'b0;
    #1;
    check("R11 new mode after edge", 32'(prg_addr), 32'h0C000);

    summary();
  end
endmodule